// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This unit chooses one of two IEEE 754 operands and hands it back bit for bit. Both operands share one format, single (32-bit) or double (64-bit), chosen by a precision flag. A 2-bit operation code picks one of four selections:

- the signed minimum;
- the signed maximum;
- the operand of smaller magnitude;
- the operand of larger magnitude.

The unit never computes a new value. It only decides which input to forward.

A NaN counts as a missing value. When one operand is NaN, the other one wins. When both are NaN, operand A is kept. Zeros of opposite sign are ordered, with -0 below +0. Ties between equal magnitudes are broken by signed value. All decisions come from comparisons on the raw bit patterns, so no floating-point arithmetic is needed.

The unit is meant to sit in a floating-point execute stage. By default its result is registered once. A parameter can remove that register.

Top module: `fp_minmax_sel`

## Requirements
- R1: Operation code 0 selects the signed minimum and code 1 the signed maximum. For two non-NaN operands of different value, they return the smaller and the larger value respectively.
- R2: When both operands are NaN, the result is operand A with its payload and sign untouched, whatever the operation code.
- R3: When exactly one operand is NaN, the result is the non-NaN operand, under all four operation codes.
- R4: Under code 0, equal operands (including +0 against -0) give the operand whose sign bit (the top bit of the format) is set. Under code 1 they give the operand whose sign bit is clear.
- R5: Code 2 returns the operand of smaller magnitude. Magnitude is every bit below the sign, read as an unsigned integer. On equal magnitudes it returns the signed-smaller operand, so -3 against 3 gives -3.
- R6: Code 3 returns the operand of larger magnitude. On equal magnitudes it returns the signed-larger operand. For -0 against +0, code 3 gives +0 and code 2 gives -0.
- R7: Infinities (all-ones exponent, zero fraction) are ordinary ordered values. Code 2 on -inf and 5 gives 5. Code 3 on +inf and -inf gives +inf.
- R8: With the precision flag low, only bits 31:0 of each operand are used, the format is 1/8/23 (sign/exponent/fraction), and result bits 63:32 are zero whatever the upper input bits hold. With the flag high, the format is 1/11/52 across all 64 bits.
- R9: With the output register enabled (the default), the result appears one clock after the inputs. While reset is asserted, the result is zero.
- R10: The result always equals, bit for bit, one of the two active-format operands. No NaN is quieted and no payload is changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset, clears the result register |
| op_a | input | 64 | Operand A (single precision in bits 31:0) |
| op_b | input | 64 | Operand B (single precision in bits 31:0) |
| is_dbl | input | 1 | 1 = double precision, 0 = single precision |
| opsel | input | 2 | 0 min, 1 max, 2 smaller magnitude, 3 larger magnitude |
| result | output | 64 | Selected operand, zero-extended in single mode |

## Verification
Two rules can both apply to the same pair of operands: NaN screening and signed-zero or equal-magnitude tie breaking. The magnitude-select codes then have to settle both the magnitude test and the signed tie in one cycle. The vector table provokes these overlaps on purpose. It pairs -0 with a NaN, +0 with -0 under every code, and opposite-signed equal magnitudes under the magnitude codes, and each result must match the exact expected bit pattern. Single-precision vectors carry junk in the upper operand bits, which tests the lane choice in the same cycle as the selection rules.

// File: rtl/fpms_pkg.sv
package fpms_pkg;

   // Operation codes driven on opsel
   typedef enum logic [1:0] {
      OP_MIN  = 2'd0,
      OP_MAX  = 2'd1,
      OP_MINA = 2'd2,
      OP_MAXA = 2'd3
   } fpms_op_e;

   // Which operand is forwarded
   typedef enum logic {
      PICK_A = 1'b0,
      PICK_B = 1'b1
   } fpms_pick_e;

   // Number of format lanes (single, double)
   localparam int FMT_CNT = 2;
   localparam int FMT_SP  = 0;
   localparam int FMT_DP  = 1;

endpackage

// File: rtl/fpms_classify.sv
module fpms_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0]   val,
   output logic                    is_nan,
   output logic                    sign,
   output logic [EXP_W+FRAC_W-1:0] mag
);
   localparam int W = EXP_W + FRAC_W + 1;

   if (EXP_W < 2) begin : g_bad_exp
      $error("fpms_classify: EXP_W must be at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("fpms_classify: FRAC_W must be at least 1");
   end

   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;

   assign sign   = val[W-1];
   assign mag    = val[W-2:0];
   assign expo   = val[W-2 -: EXP_W];
   assign frac   = val[FRAC_W-1:0];
   // all-ones exponent with any fraction bit set
   assign is_nan = (&expo) & (|frac);

endmodule

// File: rtl/fpms_order.sv
module fpms_order #(
   parameter int MAG_W = 31
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic             mag_lt,   // |a| < |b|
   output logic             mag_gt,   // |a| > |b|
   output logic             tot_lt,   // a before b, -0 below +0
   output logic             tot_gt    // a after b
);
   if (MAG_W < 2) begin : g_bad_mag
      $error("fpms_order: MAG_W must be at least 2");
   end

   assign mag_lt = (mag_a < mag_b);
   assign mag_gt = (mag_a > mag_b);

   // Signed order derived from sign and magnitude. Opposite signs are
   // decided by the sign alone, which also places -0 below +0.
   always_comb begin
      unique case ({sign_a, sign_b})
         2'b10: begin
            tot_lt = 1'b1;
            tot_gt = 1'b0;
         end
         2'b01: begin
            tot_lt = 1'b0;
            tot_gt = 1'b1;
         end
         2'b00: begin
            tot_lt = mag_lt;
            tot_gt = mag_gt;
         end
         default: begin
            tot_lt = mag_gt;
            tot_gt = mag_lt;
         end
      endcase
   end

endmodule

// File: rtl/fpms_pick.sv
module fpms_pick
   import fpms_pkg::*;
(
   input  fpms_op_e   op,
   input  logic       nan_a,
   input  logic       nan_b,
   input  logic       mag_lt,
   input  logic       mag_gt,
   input  logic       tot_lt,
   input  logic       tot_gt,
   output fpms_pick_e pick
);
   fpms_pick_e ordered;

   // Selection between two numbers
   always_comb begin
      unique case (op)
         OP_MIN:  ordered = tot_gt ? PICK_B : PICK_A;
         OP_MAX:  ordered = tot_lt ? PICK_B : PICK_A;
         OP_MINA: begin
            if (mag_gt)      ordered = PICK_B;
            else if (mag_lt) ordered = PICK_A;
            else             ordered = tot_gt ? PICK_B : PICK_A;
         end
         default: begin
            if (mag_lt)      ordered = PICK_B;
            else if (mag_gt) ordered = PICK_A;
            else             ordered = tot_lt ? PICK_B : PICK_A;
         end
      endcase
   end

   // NaN screen overrides the ordered choice
   always_comb begin
      if (nan_a && nan_b)  pick = PICK_A;
      else if (nan_a)      pick = PICK_B;
      else if (nan_b)      pick = PICK_A;
      else                 pick = ordered;
   end

endmodule

// File: rtl/fp_minmax_sel.sv
module fp_minmax_sel
   import fpms_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int SP_EXP_W  = 8,
   parameter int SP_FRAC_W = 23,
   parameter int DP_EXP_W  = 11,
   parameter int DP_FRAC_W = 52,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              is_dbl,
   input  logic [1:0]        opsel,
   output logic [DATA_W-1:0] result
);
   localparam int SP_W = SP_EXP_W + SP_FRAC_W + 1;
   localparam int DP_W = DP_EXP_W + DP_FRAC_W + 1;

   if (DP_W != DATA_W) begin : g_bad_dp
      $error("fp_minmax_sel: double format must fill DATA_W");
   end
   if (SP_W >= DP_W) begin : g_bad_sp
      $error("fp_minmax_sel: single format must be narrower than double");
   end

   fpms_op_e op_e;
   assign op_e = fpms_op_e'(opsel);

   logic [DATA_W-1:0]  lane_res [FMT_CNT];
   logic [FMT_CNT-1:0] lane_nan_a;
   logic [FMT_CNT-1:0] lane_nan_b;
   logic [FMT_CNT-1:0] lane_mag_lt;
   logic [FMT_CNT-1:0] lane_mag_gt;

   for (genvar g = 0; g < FMT_CNT; g++) begin : g_fmt
      localparam int EW = (g == FMT_SP) ? SP_EXP_W  : DP_EXP_W;
      localparam int FW = (g == FMT_SP) ? SP_FRAC_W : DP_FRAC_W;
      localparam int LW = EW + FW + 1;

      logic [LW-1:0] la, lb;
      logic [LW-2:0] ma, mb;
      logic          sa, sb, na, nb;
      logic          mlt, mgt, tlt, tgt;
      fpms_pick_e    pk;

      assign la = op_a[LW-1:0];
      assign lb = op_b[LW-1:0];

      fpms_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls_a (
         .val(la), .is_nan(na), .sign(sa), .mag(ma)
      );
      fpms_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls_b (
         .val(lb), .is_nan(nb), .sign(sb), .mag(mb)
      );
      fpms_order #(.MAG_W(LW-1)) u_ord (
         .sign_a(sa), .sign_b(sb), .mag_a(ma), .mag_b(mb),
         .mag_lt(mlt), .mag_gt(mgt), .tot_lt(tlt), .tot_gt(tgt)
      );
      fpms_pick u_pick (
         .op(op_e), .nan_a(na), .nan_b(nb),
         .mag_lt(mlt), .mag_gt(mgt), .tot_lt(tlt), .tot_gt(tgt),
         .pick(pk)
      );

      assign lane_res[g]    = (pk == PICK_B) ? DATA_W'(lb) : DATA_W'(la);
      assign lane_nan_a[g]  = na;
      assign lane_nan_b[g]  = nb;
      assign lane_mag_lt[g] = mlt;
      assign lane_mag_gt[g] = mgt;
   end

   logic [DATA_W-1:0] res_next;
   assign res_next = is_dbl ? lane_res[FMT_DP] : lane_res[FMT_SP];

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) result <= '0;
         else        result <= res_next;
      end

      AST_REG_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> result == $past(res_next)); // R9
   end else begin : g_comb
      assign result = res_next;
   end

   // ---- checks on the selection against the active-format operands ----
   logic [DATA_W-1:0] act_a, act_b;
   logic              act_nan_a, act_nan_b, act_mlt, act_mgt;
   assign act_a     = is_dbl ? op_a : DATA_W'(op_a[SP_W-1:0]);
   assign act_b     = is_dbl ? op_b : DATA_W'(op_b[SP_W-1:0]);
   assign act_nan_a = is_dbl ? lane_nan_a[FMT_DP]  : lane_nan_a[FMT_SP];
   assign act_nan_b = is_dbl ? lane_nan_b[FMT_DP]  : lane_nan_b[FMT_SP];
   assign act_mlt   = is_dbl ? lane_mag_lt[FMT_DP] : lane_mag_lt[FMT_SP];
   assign act_mgt   = is_dbl ? lane_mag_gt[FMT_DP] : lane_mag_gt[FMT_SP];

   AST_BOTH_NAN_KEEP_A: assert property (@(posedge clk) disable iff (!rst_n)
      (act_nan_a && act_nan_b) |-> res_next == act_a); // R2
   AST_ONE_NAN_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
      (act_nan_a ^ act_nan_b) |-> res_next == (act_nan_a ? act_b : act_a)); // R3
   AST_IS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      (res_next == act_a) || (res_next == act_b)); // R10
   AST_SP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !is_dbl |-> res_next[DATA_W-1:SP_W] == '0); // R8
   AST_MINA_SMALLER: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_nan_a && !act_nan_b && op_e == OP_MINA && act_mgt)
      |-> res_next == act_b); // R5
   AST_MAXA_LARGER: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_nan_a && !act_nan_b && op_e == OP_MAXA && act_mlt)
      |-> res_next == act_b); // R6

endmodule

// File: tb/sim_fp_minmax_sel.sv
module sim_fp_minmax_sel;
   localparam int CLK_P = 10;

   // double constants
   localparam logic [63:0] D_P0   = 64'h0000000000000000;
   localparam logic [63:0] D_N0   = 64'h8000000000000000;
   localparam logic [63:0] D_P1   = 64'h3FF0000000000000;
   localparam logic [63:0] D_N1   = 64'hBFF0000000000000;
   localparam logic [63:0] D_P2   = 64'h4000000000000000;
   localparam logic [63:0] D_N2   = 64'hC000000000000000;
   localparam logic [63:0] D_P3   = 64'h4008000000000000;
   localparam logic [63:0] D_N3   = 64'hC008000000000000;
   localparam logic [63:0] D_P5   = 64'h4014000000000000;
   localparam logic [63:0] D_PINF = 64'h7FF0000000000000;
   localparam logic [63:0] D_NINF = 64'hFFF0000000000000;
   localparam logic [63:0] D_QNAN = 64'h7FF8000000000000;
   localparam logic [63:0] D_SNAN = 64'h7FF0000000000001;
   localparam logic [63:0] D_NNAN = 64'hFFF8000000000123;

   localparam int NV = 36;
   // {req[3:0], dbl, op[1:0], a[63:0], b[63:0], expected[63:0]}
   localparam logic [198:0] VEC [NV] = '{
      // R1 signed min / max on distinct values
      {4'd1, 1'b1, 2'd0, D_P1, D_P2, D_P1},
      {4'd1, 1'b1, 2'd1, D_P1, D_P2, D_P2},
      {4'd1, 1'b1, 2'd0, D_N2, D_P1, D_N2},
      {4'd1, 1'b1, 2'd1, D_N2, D_N1, D_N1},
      {4'd1, 1'b1, 2'd0, D_N2, D_N1, D_N2},
      {4'd1, 1'b1, 2'd1, D_P2, D_P1, D_P2},
      // R4 signed-zero ties
      {4'd4, 1'b1, 2'd0, D_P0, D_N0, D_N0},
      {4'd4, 1'b1, 2'd1, D_N0, D_P0, D_P0},
      {4'd4, 1'b1, 2'd0, D_N0, D_P0, D_N0},
      {4'd4, 1'b1, 2'd1, D_P0, D_N0, D_P0},
      // R5 smaller magnitude
      {4'd5, 1'b1, 2'd2, D_N3, D_P3, D_N3},
      {4'd5, 1'b1, 2'd2, D_N3, D_P2, D_P2},
      {4'd5, 1'b1, 2'd2, D_P3, D_N3, D_N3},
      // R6 larger magnitude and zero pair
      {4'd6, 1'b1, 2'd3, D_N3, D_P3, D_P3},
      {4'd6, 1'b1, 2'd3, D_P2, D_N3, D_N3},
      {4'd6, 1'b1, 2'd3, D_N0, D_P0, D_P0},
      {4'd6, 1'b1, 2'd2, D_P0, D_N0, D_N0},
      // R7 infinities
      {4'd7, 1'b1, 2'd2, D_NINF, D_P5, D_P5},
      {4'd7, 1'b1, 2'd3, D_PINF, D_NINF, D_PINF},
      {4'd7, 1'b1, 2'd0, D_NINF, D_P5, D_NINF},
      {4'd7, 1'b1, 2'd1, D_P5, D_PINF, D_PINF},
      // R2 both NaN keep A
      {4'd2, 1'b1, 2'd0, D_SNAN, D_NNAN, D_SNAN},
      {4'd2, 1'b1, 2'd3, D_NNAN, D_SNAN, D_NNAN},
      // R3 one NaN gives the number
      {4'd3, 1'b1, 2'd0, D_QNAN, D_P1, D_P1},
      {4'd3, 1'b1, 2'd1, D_P2, D_QNAN, D_P2},
      {4'd3, 1'b1, 2'd2, D_NNAN, D_N3, D_N3},
      {4'd3, 1'b1, 2'd3, D_N0, D_SNAN, D_N0},
      // R10 NaN payload preserved bit for bit
      {4'd10, 1'b1, 2'd1, D_NNAN, D_QNAN, D_NNAN},
      // R8 single precision, junk in upper input bits
      {4'd8, 1'b0, 2'd0, 64'hDEADBEEF_3F800000, 64'h12345678_40000000, 64'h00000000_3F800000},
      {4'd8, 1'b0, 2'd1, 64'hDEADBEEF_3F800000, 64'h12345678_40000000, 64'h00000000_40000000},
      {4'd8, 1'b0, 2'd2, 64'hFFFFFFFF_C0400000, 64'hA5A5A5A5_40400000, 64'h00000000_C0400000},
      {4'd8, 1'b0, 2'd3, 64'hFFFFFFFF_C0400000, 64'hA5A5A5A5_40400000, 64'h00000000_40400000},
      {4'd8, 1'b0, 2'd0, 64'h7FF00000_00000000, 64'h00000001_80000000, 64'h00000000_80000000},
      {4'd8, 1'b0, 2'd3, 64'h00000000_FF800000, 64'h0000FFFF_40A00000, 64'h00000000_FF800000},
      // R2 / R3 in single precision
      {4'd2, 1'b0, 2'd0, 64'h11111111_7F800001, 64'h22222222_FFC00000, 64'h00000000_7F800001},
      {4'd3, 1'b0, 2'd1, 64'h33333333_7FC00000, 64'h44444444_C0000000, 64'h00000000_C0000000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        is_dbl = 1'b0;
   logic [1:0]  opsel = '0;
   logic [63:0] result;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   fp_minmax_sel u0 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .is_dbl(is_dbl), .opsel(opsel), .result(result)
   );

   task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      // R9 reset clears the output while inputs are busy
      op_a = D_P5; op_b = D_N3; is_dbl = 1'b1; opsel = 2'd1;
      repeat (3) @(negedge clk);
      check(9, result, 64'h0);
      rst_n = 1'b1;

      // main table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         is_dbl = VEC[i][194];
         opsel  = VEC[i][193:192];
         op_a   = VEC[i][191:128];
         op_b   = VEC[i][127:64];
         @(negedge clk);
         check(int'(VEC[i][198:195]), result, VEC[i][63:0]);
      end

      // R9 latency: output holds until the next edge
      @(negedge clk);
      is_dbl = 1'b1; opsel = 2'd0; op_a = D_P3; op_b = D_N1;
      @(negedge clk);
      check(9, result, D_N1);
      opsel = 2'd1;
      #(CLK_P/4);
      check(9, result, D_N1);
      @(negedge clk);
      check(9, result, D_P3);

      // R8 switching back to single clears the upper half
      is_dbl = 1'b0; opsel = 2'd3; op_a = D_N3; op_b = D_P3;
      @(negedge clk);
      check(8, result, 64'h0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule